// File: doc/BRIEF.md
# Receiver DC Offset Calibration Sequencer

This block orders the housekeeping steps around a packet receiver. When a receive start arrives with start-up estimation enabled, it holds the LNA at its minimum gain while the automatic DC cancellation loop settles. It then copies the automatic estimate into the manual override value and switches cancellation to manual. Finally it gives the LNA back its programmed gain, waits for the amplifier to settle and fires a one-cycle sync-search start. With start-up estimation disabled, the sync-search start follows the receive start at once and the override steps are skipped.

At the end of a packet the block emits capture strobes. One samples RSSI, timed from the byte count of the packet. On a demodulator-off request, a fixed sequence captures the four DC offset bytes and then the frequency offset estimate, and grants the switch-off. In write-back mode, the DC word captured at the end of the packet is loaded into the override register, but only when the packet passed its CRC. An abort input cancels every sequence in progress.

Top module: `dcal_seq`

## Requirements
- R1: After reset the LNA gain output equals the programmed gain, DC cancellation is automatic (`dc_manual_o` low) and no strobe is active.
- R2: A receive start with start-up estimation enabled sets cancellation to automatic and forces the LNA gain to `GAIN_MIN` for exactly `EST_CYC` cycles, starting the cycle after the start is sampled.
- R3: When the estimate wait ends, `ovr_we_o` pulses for one cycle with `ovr_val_o` equal to `dc_est_i`, and `dc_manual_o` goes high in that same cycle. This cycle is `EST_CYC` cycles after the first forced-gain cycle.
- R4: The programmed gain returns in the cycle of the override load. `sync_start_o` then pulses for one cycle, `SET_CYC` cycles after the load cycle.
- R5: A receive start with start-up estimation disabled gives a `sync_start_o` pulse in the next cycle. It causes no override write and leaves the cancellation mode and gain unchanged.
- R6: `rssi_cap_o` pulses in the cycle after byte number `pkt_len_i - 1` of the packet is strobed, or after byte 1 when `pkt_len_i` is below 2. Byte numbering restarts at each receive start.
- R7: A demodulator-off request gives four consecutive `dc_cap_o` cycles. Their `dc_idx_o` runs 0,1,2,3 and `dc_byte_o` carries `dc_est_i` bits 7:0 (I low), 15:8 (I high), 23:16 (Q low) and 31:24 (Q high). The next cycle has `freq_cap_o` and `demod_off_ok_o` high together.
- R8: With write-back enabled and `crc_err_i` low in the frequency-capture cycle, `ovr_we_o` pulses in the following cycle with the four captured bytes. If either condition fails, no write happens and `ovr_val_o` is unchanged.
- R9: An abort cancels the start-up and end-of-packet sequences. In the following cycle the gain is the programmed value and no override write, capture strobe or sync start follows from the cancelled work.
- R10: When the start-up load and an end-of-packet write-back fall in the same cycle, the start-up load wins and the write-back is dropped.
- R11: A receive start during a running start-up sequence restarts it, and the timing of R2 to R4 is counted from the new start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_start_i | input | 1 | Receive start request, one cycle |
| abort_i | input | 1 | Cancel all sequences |
| est_en_i | input | 1 | Enable start-up DC estimation |
| wb_en_i | input | 1 | Enable end-of-packet write-back |
| gain_prog_i | input | GAIN_W | Programmed LNA gain |
| dc_est_i | input | 32 | Automatic DC estimate {Q high, Q low, I high, I low} |
| byte_vld_i | input | 1 | Byte received from demodulator |
| pkt_len_i | input | LEN_W | Packet length in bytes |
| crc_err_i | input | 1 | CRC error flag of the current packet |
| demod_off_req_i | input | 1 | Request to switch the demodulator off |
| lna_gain_o | output | GAIN_W | LNA gain setting |
| dc_manual_o | output | 1 | 1 = manual override, 0 = automatic cancellation |
| ovr_we_o | output | 1 | Override value write strobe |
| ovr_val_o | output | 32 | Override value |
| rssi_cap_o | output | 1 | RSSI capture strobe |
| dc_cap_o | output | 1 | DC offset byte capture strobe |
| dc_idx_o | output | 2 | Index of the DC byte being captured |
| dc_byte_o | output | 8 | DC byte being captured |
| freq_cap_o | output | 1 | Frequency offset capture strobe |
| demod_off_ok_o | output | 1 | Demodulator may be switched off |
| sync_start_o | output | 1 | Start sync search, one cycle |

## Verification
The override register has one write port shared by two functions: the start-up load at the end of the estimate wait, and the CRC-gated write-back at the end of the frequency capture. These can land on the same clock edge. The bench starts a receive and then issues a demodulator-off request timed so that its write-back lands on the edge of the start-up load. The DC estimate input changes after the end-of-packet bytes have been captured, so the two candidate values differ. Exactly one write carrying the live estimate, and manual mode after it, show that the start-up load won.

// File: rtl/dcal_pkg.sv
package dcal_pkg;
   localparam int DC_BYTES = 4;
   localparam int BYTE_W   = 8;
   localparam int DC_W     = DC_BYTES * BYTE_W;
   localparam int IDX_W    = $clog2(DC_BYTES);
   localparam int STEP_W   = $clog2(DC_BYTES + 1);

   typedef enum logic [1:0] {
      SU_IDLE   = 2'd0,
      SU_EST    = 2'd1,
      SU_SETTLE = 2'd2
   } su_state_e;
endpackage

// File: rtl/dcal_cnt.sv
module dcal_cnt #(
   parameter int W = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_val,
   input  logic         en,
   output logic         zero
);
   logic [W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 cnt_q <= '0;
      else if (load)              cnt_q <= load_val;
      else if (en && cnt_q != '0) cnt_q <= cnt_q - 1'b1;
   end

   assign zero = (cnt_q == '0);
endmodule

// File: rtl/dcal_startup.sv
module dcal_startup
   import dcal_pkg::*;
#(
   parameter int EST_CYC = 8,
   parameter int SET_CYC = 6
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start_i,
   input  logic abort_i,
   input  logic est_en_i,
   output logic force_min_o,
   output logic ld_req_o,
   output logic auto_clr_o,
   output logic sync_req_o
);
   localparam int CMAX = (EST_CYC > SET_CYC) ? EST_CYC : SET_CYC;
   localparam int CW   = $clog2(CMAX + 1);

   su_state_e st_q, st_d;
   logic      go, est_zero, set_zero, est_done, set_done;

   assign go       = start_i && !abort_i;
   assign est_done = (st_q == SU_EST)    && est_zero && !abort_i && !start_i;
   assign set_done = (st_q == SU_SETTLE) && set_zero && !abort_i && !start_i;

   dcal_cnt #(.W(CW)) u_est_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (go && est_en_i),
      .load_val (CW'(EST_CYC - 1)),
      .en       (st_q == SU_EST),
      .zero     (est_zero)
   );

   dcal_cnt #(.W(CW)) u_set_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (est_done),
      .load_val (CW'(SET_CYC - 1)),
      .en       (st_q == SU_SETTLE),
      .zero     (set_zero)
   );

   always_comb begin
      st_d = st_q;
      if (abort_i)       st_d = SU_IDLE;
      else if (go)       st_d = est_en_i ? SU_EST : SU_IDLE;
      else if (est_done) st_d = SU_SETTLE;
      else if (set_done) st_d = SU_IDLE;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st_q <= SU_IDLE;
      else        st_q <= st_d;
   end

   assign force_min_o = (st_q == SU_EST);
   assign ld_req_o    = est_done;
   assign auto_clr_o  = go && est_en_i;
   assign sync_req_o  = (go && !est_en_i) || set_done;
endmodule

// File: rtl/dcal_eop.sv
module dcal_eop
   import dcal_pkg::*;
#(
   parameter int LEN_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic              abort_i,
   input  logic              byte_vld_i,
   input  logic [LEN_W-1:0]  pkt_len_i,
   input  logic              off_req_i,
   input  logic              wb_en_i,
   input  logic              crc_err_i,
   input  logic [DC_W-1:0]   dc_est_i,
   output logic              rssi_cap_o,
   output logic              dc_cap_o,
   output logic [IDX_W-1:0]  dc_idx_o,
   output logic [BYTE_W-1:0] dc_byte_o,
   output logic              freq_cap_o,
   output logic              wb_req_o,
   output logic [DC_W-1:0]   wb_val_o
);
   logic [LEN_W-1:0]  bcnt_q, bcnt_nx, rssi_pos;
   logic              rssi_q;
   logic              busy_q;
   logic [STEP_W-1:0] step_q;
   logic [DC_W-1:0]   cap_q;

   assign bcnt_nx  = bcnt_q + 1'b1;
   assign rssi_pos = (pkt_len_i < LEN_W'(2)) ? LEN_W'(1) : pkt_len_i - 1'b1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bcnt_q <= '0;
         rssi_q <= 1'b0;
      end else if (start_i || abort_i) begin
         bcnt_q <= '0;
         rssi_q <= 1'b0;
      end else begin
         rssi_q <= byte_vld_i && (bcnt_nx == rssi_pos);
         if (byte_vld_i) bcnt_q <= bcnt_nx;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         step_q <= '0;
         cap_q  <= '0;
      end else if (abort_i) begin
         busy_q <= 1'b0;
         step_q <= '0;
      end else if (!busy_q) begin
         if (off_req_i) begin
            busy_q <= 1'b1;
            step_q <= '0;
         end
      end else if (step_q == STEP_W'(DC_BYTES)) begin
         busy_q <= 1'b0;
         step_q <= '0;
      end else begin
         cap_q[step_q[IDX_W-1:0]*BYTE_W +: BYTE_W] <= dc_byte_o;
         step_q <= step_q + 1'b1;
      end
   end

   assign rssi_cap_o = rssi_q;
   assign dc_cap_o   = busy_q && (step_q < STEP_W'(DC_BYTES));
   assign dc_idx_o   = step_q[IDX_W-1:0];
   assign dc_byte_o  = dc_est_i[dc_idx_o*BYTE_W +: BYTE_W];
   assign freq_cap_o = busy_q && (step_q == STEP_W'(DC_BYTES));
   assign wb_req_o   = freq_cap_o && wb_en_i && !crc_err_i && !abort_i;
   assign wb_val_o   = cap_q;
endmodule

// File: rtl/dcal_seq.sv
module dcal_seq
   import dcal_pkg::*;
#(
   parameter int GAIN_W   = 4,
   parameter int GAIN_MIN = 0,
   parameter int EST_CYC  = 8,
   parameter int SET_CYC  = 6,
   parameter int LEN_W    = 8,
   parameter bit GAIN_REG = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rx_start_i,
   input  logic              abort_i,
   input  logic              est_en_i,
   input  logic              wb_en_i,
   input  logic [GAIN_W-1:0] gain_prog_i,
   input  logic [31:0]       dc_est_i,
   input  logic              byte_vld_i,
   input  logic [LEN_W-1:0]  pkt_len_i,
   input  logic              crc_err_i,
   input  logic              demod_off_req_i,
   output logic [GAIN_W-1:0] lna_gain_o,
   output logic              dc_manual_o,
   output logic              ovr_we_o,
   output logic [31:0]       ovr_val_o,
   output logic              rssi_cap_o,
   output logic              dc_cap_o,
   output logic [1:0]        dc_idx_o,
   output logic [7:0]        dc_byte_o,
   output logic              freq_cap_o,
   output logic              demod_off_ok_o,
   output logic              sync_start_o
);
   if (EST_CYC < 1 || SET_CYC < 1) begin : g_bad_wait
      $error("dcal_seq: EST_CYC and SET_CYC must be at least 1");
   end
   if (GAIN_W < 1 || GAIN_MIN < 0 || GAIN_MIN >= (1 << GAIN_W)) begin : g_bad_gain
      $error("dcal_seq: GAIN_MIN must fit in GAIN_W bits");
   end
   if (LEN_W < 2) begin : g_bad_len
      $error("dcal_seq: LEN_W must be at least 2");
   end
   if (DC_W != 32 || IDX_W != 2) begin : g_bad_dc
      $error("dcal_seq: port widths assume four DC bytes");
   end

   logic            force_min, ld_req, auto_clr, sync_req;
   logic            wb_req;
   logic [DC_W-1:0] wb_val;
   logic            manual_q, ovr_we_q, sync_q;
   logic [DC_W-1:0] ovr_q;
   logic [GAIN_W-1:0] gain_c;

   dcal_startup #(
      .EST_CYC (EST_CYC),
      .SET_CYC (SET_CYC)
   ) u_startup (
      .clk         (clk),
      .rst_n       (rst_n),
      .start_i     (rx_start_i),
      .abort_i     (abort_i),
      .est_en_i    (est_en_i),
      .force_min_o (force_min),
      .ld_req_o    (ld_req),
      .auto_clr_o  (auto_clr),
      .sync_req_o  (sync_req)
   );

   dcal_eop #(
      .LEN_W (LEN_W)
   ) u_eop (
      .clk        (clk),
      .rst_n      (rst_n),
      .start_i    (rx_start_i),
      .abort_i    (abort_i),
      .byte_vld_i (byte_vld_i),
      .pkt_len_i  (pkt_len_i),
      .off_req_i  (demod_off_req_i),
      .wb_en_i    (wb_en_i),
      .crc_err_i  (crc_err_i),
      .dc_est_i   (dc_est_i),
      .rssi_cap_o (rssi_cap_o),
      .dc_cap_o   (dc_cap_o),
      .dc_idx_o   (dc_idx_o),
      .dc_byte_o  (dc_byte_o),
      .freq_cap_o (freq_cap_o),
      .wb_req_o   (wb_req),
      .wb_val_o   (wb_val)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         manual_q <= 1'b0;
         ovr_we_q <= 1'b0;
         ovr_q    <= '0;
         sync_q   <= 1'b0;
      end else begin
         sync_q   <= sync_req;
         ovr_we_q <= ld_req || wb_req;
         if (ld_req)      ovr_q <= dc_est_i;
         else if (wb_req) ovr_q <= wb_val;
         if (ld_req)        manual_q <= 1'b1;
         else if (auto_clr) manual_q <= 1'b0;
      end
   end

   assign gain_c = force_min ? GAIN_W'(GAIN_MIN) : gain_prog_i;

   if (GAIN_REG) begin : g_gain_reg
      logic [GAIN_W-1:0] gain_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) gain_q <= gain_prog_i;
         else        gain_q <= gain_c;
      end
      assign lna_gain_o = gain_q;
   end else begin : g_gain_comb
      assign lna_gain_o = gain_c;
   end

   assign dc_manual_o    = manual_q;
   assign ovr_we_o       = ovr_we_q;
   assign ovr_val_o      = ovr_q;
   assign sync_start_o   = sync_q;
   assign demod_off_ok_o = freq_cap_o;
endmodule

// File: rtl/dcal_seq_chk.sv
module dcal_seq_chk #(
   parameter int GAIN_W   = 4,
   parameter int GAIN_MIN = 0,
   parameter bit GAIN_REG = 1'b0
) (
   input logic              clk,
   input logic              rst_n,
   input logic              abort_i,
   input logic [GAIN_W-1:0] gain_prog_i,
   input logic [GAIN_W-1:0] lna_gain_o,
   input logic              dc_manual_o,
   input logic              ovr_we_o,
   input logic              dc_cap_o,
   input logic [1:0]        dc_idx_o,
   input logic              freq_cap_o,
   input logic              sync_start_o
);
   AST_MANUAL_WITH_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(dc_manual_o) |-> ovr_we_o); // R3

   AST_FREQ_AFTER_LAST_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
      freq_cap_o |-> ($past(dc_cap_o) && $past(dc_idx_o) == 2'd3)); // R7

   AST_DC_IDX_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (dc_cap_o && dc_idx_o != 2'd0) |-> ($past(dc_cap_o) && dc_idx_o == $past(dc_idx_o) + 2'd1)); // R7

   AST_CAP_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({dc_cap_o, freq_cap_o})); // R7

   AST_ABORT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      $past(abort_i) |-> (!ovr_we_o && !sync_start_o && !dc_cap_o && !freq_cap_o)); // R9

   if (!GAIN_REG) begin : g_gain_chk
      AST_GAIN_MIN_BEFORE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(dc_manual_o) |-> $past(lna_gain_o) == GAIN_W'(GAIN_MIN)); // R2

      AST_ABORT_GAIN: assert property (@(posedge clk) disable iff (!rst_n)
         $past(abort_i) |-> lna_gain_o == gain_prog_i); // R9
   end
endmodule

bind dcal_seq dcal_seq_chk #(
   .GAIN_W   (GAIN_W),
   .GAIN_MIN (GAIN_MIN),
   .GAIN_REG (GAIN_REG)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .abort_i      (abort_i),
   .gain_prog_i  (gain_prog_i),
   .lna_gain_o   (lna_gain_o),
   .dc_manual_o  (dc_manual_o),
   .ovr_we_o     (ovr_we_o),
   .dc_cap_o     (dc_cap_o),
   .dc_idx_o     (dc_idx_o),
   .freq_cap_o   (freq_cap_o),
   .sync_start_o (sync_start_o)
);

// File: tb/dcal_seq_tb.sv
module dcal_seq_tb;
   localparam int GW  = 4;
   localparam int EST = 8;
   localparam int SET = 6;
   localparam int LW  = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          rx_start = 1'b0, abort = 1'b0, est_en = 1'b0, wb_en = 1'b0;
   logic [GW-1:0] gain_prog = 4'd9;
   logic [31:0]   dc_est = 32'h0;
   logic          byte_vld = 1'b0, crc_err = 1'b0, demod_off = 1'b0;
   logic [LW-1:0] pkt_len = 8'd5;
   logic [GW-1:0] lna_gain;
   logic          dc_manual, ovr_we, rssi_cap, dc_cap, freq_cap, off_ok, sync_start;
   logic [31:0]   ovr_val;
   logic [1:0]    dc_idx;
   logic [7:0]    dc_byte;

   int  cyc = 0;
   int  checks = 0;
   int  fails = 0;
   bit  mon_on = 1'b0;
   bit  done = 1'b0;

   typedef struct {
      int          at;
      int          kind;
      logic [31:0] val;
      string       rq;
   } exp_t;
   exp_t exp_q[$];

   string kname [5] = '{"ovr_write", "sync_start", "rssi_cap", "dc_cap", "freq_cap"};
   string kreq  [5] = '{"R3/R8/R9/R10", "R4/R5/R9", "R6", "R7/R9", "R7/R9"};

   always #5 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   dcal_seq #(
      .GAIN_W(GW), .GAIN_MIN(0), .EST_CYC(EST), .SET_CYC(SET), .LEN_W(LW), .GAIN_REG(1'b0)
   ) u_dut (
      .clk(clk), .rst_n(rst_n), .rx_start_i(rx_start), .abort_i(abort),
      .est_en_i(est_en), .wb_en_i(wb_en), .gain_prog_i(gain_prog), .dc_est_i(dc_est),
      .byte_vld_i(byte_vld), .pkt_len_i(pkt_len), .crc_err_i(crc_err),
      .demod_off_req_i(demod_off), .lna_gain_o(lna_gain), .dc_manual_o(dc_manual),
      .ovr_we_o(ovr_we), .ovr_val_o(ovr_val), .rssi_cap_o(rssi_cap), .dc_cap_o(dc_cap),
      .dc_idx_o(dc_idx), .dc_byte_o(dc_byte), .freq_cap_o(freq_cap),
      .demod_off_ok_o(off_ok), .sync_start_o(sync_start)
   );

   task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] expv);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %h expected %h (cycle %0d)", rq, act, expv, cyc);
      end
   endtask

   task automatic push(input int at, input int kind, input logic [31:0] val, input string rq);
      exp_t e;
      e.at = at; e.kind = kind; e.val = val; e.rq = rq;
      exp_q.push_back(e);
   endtask

   // monitor: compares observed strobes against the scoreboard queue
   logic        obs [5];
   logic [31:0] ov  [5];
   always @(negedge clk) begin
      #2;
      if (rst_n && mon_on) begin
         obs[0] = ovr_we;     ov[0] = ovr_val;
         obs[1] = sync_start; ov[1] = 32'd0;
         obs[2] = rssi_cap;   ov[2] = 32'd0;
         obs[3] = dc_cap;     ov[3] = {22'd0, dc_idx, dc_byte};
         obs[4] = freq_cap;   ov[4] = {31'd0, off_ok};
         for (int i = exp_q.size() - 1; i >= 0; i--) begin
            if (exp_q[i].at == cyc) begin
               chk(obs[exp_q[i].kind] && ov[exp_q[i].kind] == exp_q[i].val,
                   {exp_q[i].rq, " ", kname[exp_q[i].kind]},
                   obs[exp_q[i].kind] ? ov[exp_q[i].kind] : 32'hxxxxxxxx, exp_q[i].val);
               obs[exp_q[i].kind] = 1'b0;
               exp_q.delete(i);
            end else if (exp_q[i].at < cyc) begin
               chk(1'b0, {exp_q[i].rq, " missing ", kname[exp_q[i].kind]}, 32'd0, exp_q[i].val);
               exp_q.delete(i);
            end
         end
         for (int k = 0; k < 5; k++) begin
            if (obs[k]) chk(1'b0, {kreq[k], " unexpected ", kname[k]}, ov[k], 32'd0);
         end
      end
   end

   task automatic run_eop(input bit wb, input bit crc, input logic [31:0] word);
      int d;
      @(negedge clk);
      d = cyc;
      wb_en = wb; crc_err = crc; dc_est = word; demod_off = 1'b1;
      for (int k = 0; k < 4; k++) push(d + 1 + k, 3, {22'd0, 2'(k), word[k*8 +: 8]}, "R7");
      push(d + 5, 4, 32'd1, "R7");
      if (wb && !crc) push(d + 6, 0, word, "R8");
      @(negedge clk);
      demod_off = 1'b0;
      repeat (7) @(negedge clk);
   endtask

   initial begin
      int c;
      int d;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      mon_on = 1'b1;
      @(negedge clk); #1;
      chk(lna_gain == gain_prog, "R1 gain", 32'(lna_gain), 32'(gain_prog));
      chk(!dc_manual, "R1 mode", 32'(dc_manual), 32'd0);
      chk(!ovr_we && !sync_start && !dc_cap && !freq_cap && !rssi_cap, "R1 strobes", 32'(ovr_we), 32'd0);

      // R2 R3 R4: start-up estimation
      @(negedge clk);
      c = cyc; dc_est = 32'h5A3C1E0F; est_en = 1'b1; rx_start = 1'b1;
      push(c + 1 + EST, 0, 32'h5A3C1E0F, "R3");
      push(c + 1 + EST + SET, 1, 32'd0, "R4");
      @(negedge clk); rx_start = 1'b0; #1;
      chk(lna_gain == 4'd0, "R2 gain forced", 32'(lna_gain), 32'd0);
      repeat (EST - 1) @(negedge clk);
      #1;
      chk(lna_gain == 4'd0, "R2 gain forced last", 32'(lna_gain), 32'd0);
      chk(!dc_manual, "R2 mode automatic", 32'(dc_manual), 32'd0);
      @(negedge clk); #1;
      chk(lna_gain == gain_prog, "R4 gain restored", 32'(lna_gain), 32'(gain_prog));
      chk(dc_manual, "R3 mode manual", 32'(dc_manual), 32'd1);
      repeat (SET + 2) @(negedge clk);

      // R5: estimation disabled
      @(negedge clk);
      c = cyc; est_en = 1'b0; rx_start = 1'b1;
      push(c + 1, 1, 32'd0, "R5");
      @(negedge clk); rx_start = 1'b0; #1;
      chk(dc_manual, "R5 mode unchanged", 32'(dc_manual), 32'd1);
      chk(lna_gain == gain_prog, "R5 gain", 32'(lna_gain), 32'(gain_prog));
      repeat (3) @(negedge clk);

      // R6: RSSI timing, length 5 then length 1
      pkt_len = 8'd5;
      for (int b = 1; b <= 5; b++) begin
         @(negedge clk);
         byte_vld = 1'b1;
         if (b == 4) push(cyc + 1, 2, 32'd0, "R6");
         @(negedge clk);
         byte_vld = 1'b0;
      end
      @(negedge clk);
      c = cyc; rx_start = 1'b1;
      push(c + 1, 1, 32'd0, "R5");
      @(negedge clk); rx_start = 1'b0; pkt_len = 8'd1;
      @(negedge clk); byte_vld = 1'b1;
      push(cyc + 1, 2, 32'd0, "R6");
      @(negedge clk); byte_vld = 1'b0;
      repeat (2) @(negedge clk);

      // R7 R8: end-of-packet capture and write-back
      run_eop(1'b1, 1'b0, 32'hD4C3B2A1);
      run_eop(1'b1, 1'b1, 32'h11223344);
      #1 chk(ovr_val == 32'hD4C3B2A1, "R8 crc error keeps value", ovr_val, 32'hD4C3B2A1);
      run_eop(1'b0, 1'b0, 32'h55667788);
      #1 chk(ovr_val == 32'hD4C3B2A1, "R8 disabled keeps value", ovr_val, 32'hD4C3B2A1);

      // R9: abort during estimate wait
      @(negedge clk);
      c = cyc; est_en = 1'b1; rx_start = 1'b1;
      @(negedge clk); rx_start = 1'b0;
      repeat (3) @(negedge clk);
      abort = 1'b1;
      @(negedge clk); abort = 1'b0; #1;
      chk(lna_gain == gain_prog, "R9 gain after abort", 32'(lna_gain), 32'(gain_prog));
      repeat (EST + SET + 4) @(negedge clk);

      // R9: abort during DC capture
      @(negedge clk);
      d = cyc; wb_en = 1'b1; crc_err = 1'b0; dc_est = 32'hCAFE0123; demod_off = 1'b1;
      push(d + 1, 3, {22'd0, 2'd0, 8'h23}, "R9");
      push(d + 2, 3, {22'd0, 2'd1, 8'h01}, "R9");
      @(negedge clk); demod_off = 1'b0;
      @(negedge clk); abort = 1'b1;
      @(negedge clk); abort = 1'b0;
      repeat (8) @(negedge clk);

      // R10: start-up load and write-back on the same edge
      @(negedge clk);
      c = cyc; dc_est = 32'h0BADF00D; est_en = 1'b1; rx_start = 1'b1;
      push(c + 1 + EST, 0, 32'h600DCAFE, "R10");
      push(c + 1 + EST + SET, 1, 32'd0, "R10");
      @(negedge clk); rx_start = 1'b0;
      while (cyc < c + EST - 5) @(negedge clk);
      demod_off = 1'b1; wb_en = 1'b1; crc_err = 1'b0;
      for (int k = 0; k < 4; k++) push(cyc + 1 + k, 3, {22'd0, 2'(k), dc_est[k*8 +: 8]}, "R10");
      push(cyc + 5, 4, 32'd1, "R10");
      @(negedge clk); demod_off = 1'b0;
      while (cyc < c + EST) @(negedge clk);
      dc_est = 32'h600DCAFE;
      @(negedge clk); #1;
      chk(ovr_val == 32'h600DCAFE, "R10 start-up value wins", ovr_val, 32'h600DCAFE);
      chk(dc_manual, "R10 manual after load", 32'(dc_manual), 32'd1);
      repeat (SET + 3) @(negedge clk);

      // R11: restart during estimate wait
      @(negedge clk);
      c = cyc; rx_start = 1'b1;
      @(negedge clk); rx_start = 1'b0;
      @(negedge clk);
      @(negedge clk);
      rx_start = 1'b1;
      push(c + 4 + EST, 0, 32'h600DCAFE, "R11");
      push(c + 4 + EST + SET, 1, 32'd0, "R11");
      @(negedge clk); rx_start = 1'b0;
      repeat (EST + SET + 4) @(negedge clk);

      #3;
      foreach (exp_q[i]) chk(1'b0, {exp_q[i].rq, " never seen"}, 32'd0, exp_q[i].val);
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      #2_000_000;
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end
endmodule